// File: doc/BRIEF.md
# Time-Shared Two-Winding Peak Current Chopper

This block regulates the peak current in two motor windings, A and B, with a single shared sense comparator. An oscillator tick is divided by two to make the chopping clock. On each chopping clock the block picks one winding and sets that winding's ON output. The same winding stays selected until the comparator reports that its sense voltage has reached the reference. The `sel_b` output steers the comparator to the winding being watched. After the comparator trips, that winding recirculates (ON low) and the sense path is free for the other winding.

If the comparator reports back within one chopping period, the windings alternate every chopping clock. Each winding then gets one ON set per four oscillator periods, a 50/50 share. If the trip arrives only after the next chopping clock, the switch to the other winding waits for the chopping clock after the trip. The sharing period then grows to six oscillator periods with a 67/33 share. This is the situation while a phase change is in progress.

For a programmable number of system clocks after each set, the comparator is ignored. This gives a minimum ON time. A per-winding enable stops a winding from being set. The slot of a disabled winding is left idle.

Top module: `twin_chopper`

## Requirements
- R1: While `rst_n` is low, and after reset is released, `on_a`, `on_b` and `sel_b` are 0 until the first chopping clock. `sel_b` = 0 means winding A is selected, and 1 means winding B.
- R2: Chopping clocks fall on the 1st, 3rd, 5th… `osc_tick` pulse after reset. On a chopping clock, the ON output of the winding selected from that clock onward is set, one system clock after the tick. The very first chopping clock selects winding A.
- R3: When `trip` is high, the selected winding's ON is high and blanking has ended, that ON output goes low on the next clock edge.
- R4: On a chopping clock where the selected winding has already been reset by a trip, the selection moves to the other winding. So with prompt trips, A and B alternate on successive chopping clocks.
- R5: For `blank_len` system clocks after a set, `trip` is ignored. With `blank_len` = 0, a trip in the cycle right after the set is honoured.
- R6: If a chopping clock arrives while the selected winding is still ON, the selection is kept and the winding stays ON. The change to the other winding happens at the first chopping clock after the trip.
- R7: A winding whose enable is low at its chopping clock is not set. Its slot passes idle, and the selection moves on at the next chopping clock.
- R8: At most the selected winding is ON. `trip` while the selected winding is OFF changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | One-cycle pulse per oscillator period |
| trip | input | 1 | Comparator: sense voltage reached the reference |
| en_a | input | 1 | Winding A enable |
| en_b | input | 1 | Winding B enable |
| blank_len | input | BLANK_W | Blanking length in system clocks |
| on_a | output | 1 | Winding A ON |
| on_b | output | 1 | Winding B ON |
| sel_b | output | 1 | Comparator watches winding B when 1 |

## Verification
A wrong internal state shows at the ports within one chopping period.

- A divider out of phase moves the next ON rise by one oscillator tick.
- A stale completion flag makes `sel_b` toggle while a winding is still ON, or freeze while both are OFF. This is caught at the next chopping clock.
- A blanking counter that is off by one turns an early trip into a premature ON fall in the same cycle.

The checks therefore sample ON and select a few cycles after every tick and every trip.

// File: rtl/twin_chopper.sv
module twin_chopper #(
  parameter int BLANK_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               osc_tick,
  input  logic               trip,
  input  logic               en_a,
  input  logic               en_b,
  input  logic [BLANK_W-1:0] blank_len,
  output logic               on_a,
  output logic               on_b,
  output logic               sel_b
);

  localparam logic [BLANK_W-1:0] ONE = {{(BLANK_W-1){1'b0}}, 1'b1};

  logic               div_q, armed_q, done_q, sel_q, oa_q, ob_q;
  logic [BLANK_W-1:0] bcnt_q;

  wire chop    = osc_tick & ~div_q;
  wire cur_on  = sel_q ? ob_q : oa_q;
  wire advance = chop & (~armed_q | done_q);
  wire nsel    = (armed_q & done_q) ? ~sel_q : sel_q;
  wire nen     = nsel ? en_b : en_a;
  wire hit     = trip & cur_on & (bcnt_q == '0) & ~chop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q   <= 1'b0;
      armed_q <= 1'b0;
      done_q  <= 1'b0;
      sel_q   <= 1'b0;
      oa_q    <= 1'b0;
      ob_q    <= 1'b0;
      bcnt_q  <= '0;
    end else begin
      if (osc_tick) div_q <= ~div_q;
      if (advance) begin
        armed_q <= 1'b1;
        sel_q   <= nsel;
        done_q  <= ~nen;
        bcnt_q  <= blank_len;
        if (nen) begin
          if (nsel) ob_q <= 1'b1;
          else      oa_q <= 1'b1;
        end
      end else begin
        if (bcnt_q != '0) bcnt_q <= bcnt_q - ONE;
        if (hit) begin
          done_q <= 1'b1;
          if (sel_q) ob_q <= 1'b0;
          else       oa_q <= 1'b0;
        end
      end
    end
  end

  assign on_a  = oa_q;
  assign on_b  = ob_q;
  assign sel_b = sel_q;

endmodule

// File: rtl/twin_chopper_chk.sv
module twin_chopper_chk (
  input logic clk,
  input logic rst_n,
  input logic osc_tick,
  input logic trip,
  input logic en_a,
  input logic en_b,
  input logic on_a,
  input logic on_b,
  input logic sel_b
);

  // R8
  only_sel_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(on_a && sel_b) && !(on_b && !sel_b));

  // R4
  sel_moves_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_b != $past(sel_b)) |-> (!$past(on_a) && !$past(on_b) && $past(osc_tick)));

  // R3
  a_falls_on_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(on_a) |-> $past(trip));

  // R3
  b_falls_on_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(on_b) |-> $past(trip));

  // R7
  a_rise_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(on_a) |-> ($past(en_a) && $past(osc_tick)));

  // R7
  b_rise_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(on_b) |-> ($past(en_b) && $past(osc_tick)));

endmodule

bind twin_chopper twin_chopper_chk u_chk (
  .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .trip(trip),
  .en_a(en_a), .en_b(en_b), .on_a(on_a), .on_b(on_b), .sel_b(sel_b)
);

// File: tb/twin_chopper_tb.sv
module twin_chopper_tb;

  localparam int BW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc_tick = 1'b0;
  logic trip = 1'b0;
  logic en_a = 1'b1;
  logic en_b = 1'b1;
  logic [BW-1:0] blank_len = 8'd3;
  logic on_a, on_b, sel_b;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  twin_chopper #(.BLANK_W(BW)) u_dut (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .trip(trip),
    .en_a(en_a), .en_b(en_b), .blank_len(blank_len),
    .on_a(on_a), .on_b(on_b), .sel_b(sel_b)
  );

  // op: 0 idle, 1 tick, 2 trip, 3 tick then trip next cycle
  // fields: op[10:9] en_a[8] en_b[7] exp_a[6] exp_b[5] exp_sel[4] req[3:0]
  localparam int NV = 19;
  localparam logic [10:0] VEC [NV] = '{
    {2'd3, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'd5}, // R5 early trip ignored, R2 first chop sets A
    {2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd3}, // R3
    {2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd2}, // R2 second tick no chop
    {2'd1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 4'd4}, // R4 to B
    {2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'd3}, // R3
    {2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'd2}, // R2
    {2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'd4}, // R4 back to A
    {2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'd2}, // R2
    {2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'd6}, // R6 late, kept
    {2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd3}, // R3
    {2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd2}, // R2
    {2'd1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 4'd6}, // R6 deferred switch
    {2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'd3}, // R3
    {2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'd2}, // R2
    {2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd7}, // R7 A slot idle
    {2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd7}, // R7
    {2'd1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'd7}, // R7 B after idle slot
    {2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'd3}, // R3
    {2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'd8}  // R8 trip while off
  };

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(input int req, input logic xa, input logic xb, input logic xs);
    checks++;
    if ({on_a, on_b, sel_b} !== {xa, xb, xs}) begin
      fails++;
      $display("FAIL R%0d: on_a/on_b/sel_b = %b%b%b, expected %b%b%b",
               req, on_a, on_b, sel_b, xa, xb, xs);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    osc_tick = 1'b0;
    trip = 1'b0;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    check(1, 1'b0, 1'b0, 1'b0);
    wait_cyc(5);
    check(1, 1'b0, 1'b0, 1'b0);

    for (int k = 0; k < NV; k++) begin
      en_a = VEC[k][8];
      en_b = VEC[k][7];
      case (VEC[k][10:9])
        2'd1: begin osc_tick = 1'b1; @(negedge clk); osc_tick = 1'b0; end
        2'd2: begin trip = 1'b1; @(negedge clk); trip = 1'b0; end
        2'd3: begin
          osc_tick = 1'b1; @(negedge clk); osc_tick = 1'b0;
          trip = 1'b1; @(negedge clk); trip = 1'b0;
        end
        default: @(negedge clk);
      endcase
      wait_cyc(5);
      check(int'(VEC[k][3:0]), VEC[k][6], VEC[k][5], VEC[k][4]);
    end

    // R5 zero blanking: trip right after set is honoured
    blank_len = 8'd0;
    en_a = 1'b1;
    en_b = 1'b1;
    do_reset();
    osc_tick = 1'b1; @(negedge clk); osc_tick = 1'b0;
    check(5, 1'b1, 1'b0, 1'b0);
    trip = 1'b1; @(negedge clk); trip = 1'b0;
    check(5, 1'b0, 1'b0, 1'b0);

    // R5 trip on the last blanked cycle ignored, first free cycle honoured
    blank_len = 8'd2;
    do_reset();
    osc_tick = 1'b1; @(negedge clk); osc_tick = 1'b0;
    wait_cyc(1);
    trip = 1'b1; @(negedge clk); trip = 1'b0;
    check(5, 1'b1, 1'b0, 1'b0);
    trip = 1'b1; @(negedge clk); trip = 1'b0;
    check(5, 1'b0, 1'b0, 1'b0);

    // R7 both disabled: no winding is ever set, selection still steps
    en_a = 1'b0;
    en_b = 1'b0;
    do_reset();
    osc_tick = 1'b1; @(negedge clk); osc_tick = 1'b0;
    wait_cyc(3);
    osc_tick = 1'b1; @(negedge clk); osc_tick = 1'b0;
    wait_cyc(3);
    osc_tick = 1'b1; @(negedge clk); osc_tick = 1'b0;
    wait_cyc(2);
    check(7, 1'b0, 1'b0, 1'b1);

    // R1 reset in the middle of an ON period
    en_a = 1'b1;
    en_b = 1'b1;
    do_reset();
    osc_tick = 1'b1; @(negedge clk); osc_tick = 1'b0;
    check(2, 1'b1, 1'b0, 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    check(1, 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule